// File: doc/BRIEF.md
# I2C Bus Condition Sequencer with Occupancy Flag

This block is the condition-generation part of an I2C master. On a register-style write it produces a START, a repeated START or a STOP on the two open-drain bus lines. It also watches both lines to keep a bus-occupied flag. That flag is raised by any START seen on the bus, whether this master or another one made it, and it is dropped by any STOP. The flag and the request share one bit. The write value of that bit selects START (1) or STOP (0). A qualifier bit written as 1 turns the write into a no-op.

The timing of every condition comes from an internal half-period counter. Its length is chosen by a 4-bit clock-select code from a fixed table of non-power-of-two divisors. In clocked synchronous mode the block makes no conditions and the occupancy flag is held at 0. Data shifting, acknowledge, arbitration and addressing belong to other blocks.

The line outputs are pull-low enables: 1 drives the pad low and 0 releases it. The pad levels come back through the `sdaIn`/`sclIn` inputs.

Top module: `i2c_cond_master`

## Requirements
- R1: With `syncMode`=0, a falling `sdaIn` while `sclIn` is high sets `busBusy` no later than 3 clock cycles after the pad change.
- R2: With `syncMode`=0, a rising `sdaIn` while `sclIn` is high clears `busBusy`. When the pad changes just after clock edge P0, the flag is 0 after edge P0+3.
- R3: A write (`wrStb`=1) with `wrBusy`=1, `wrQual`=0 makes a START. SDA is pulled low while SCL is high, and SCL is pulled low exactly H cycles later. If this master already holds the bus, the same write makes a repeated START: SDA is released, SCL is released H cycles later, SDA is pulled low H cycles after that, and SCL is pulled low H cycles after that.
- R4: A write with `wrBusy`=0, `wrQual`=0 makes a STOP. SDA is pulled low, SCL is released H cycles later, and SDA is released exactly H cycles after SCL.
- R5: A write with `wrQual`=1 changes neither `busBusy` nor `sdaOe`/`sclOe`.
- R6: With `syncMode`=1, `busBusy` reads 0 even when a START appears on the bus, and writes produce no line activity.
- R7: H is half the divisor selected by `clkSel`. Codes 0 to 7 select 28, 40, 48, 64, 80, 100, 112, 128. Codes 8 to 15 select twice the value of code minus 8 (56 up to 256).
- R8: After reset `busBusy`=0, `sdaOe`=0, `sclOe`=0, and the half-period counter is cleared.
- R9: A write that arrives while a condition sequence is still running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncMode | input | 1 | 1 selects clocked synchronous format, 0 selects I2C |
| clkSel | input | 4 | Divisor select code |
| wrStb | input | 1 | One-cycle write strobe for the control bits |
| wrBusy | input | 1 | Busy bit written: 1 requests START, 0 requests STOP |
| wrQual | input | 1 | Qualifier bit written; 1 makes the write a no-op |
| sdaIn | input | 1 | SDA pad level |
| sclIn | input | 1 | SCL pad level |
| sdaOe | output | 1 | 1 pulls SDA low |
| sclOe | output | 1 | 1 pulls SCL low |
| busBusy | output | 1 | Bus occupied flag |

## Verification
The bus monitor clearing the flag on another master's STOP and a START request being accepted can land in the same clock cycle. The bench releases SDA on a bus held by a simulated second master. It then times the request write so that it is sampled at exactly the edge where the detected STOP clears `busBusy`. The expected result is that the flag reads 0 right after that edge. The START then still appears with correct H spacing and sets the flag again. A scoreboard compares every START and STOP seen on the wired bus, with its measured spacing, against the expected queue. That queue includes the conditions made by the simulated second master.

// File: rtl/i2cc_pkg.sv
`timescale 1ns/1ps
package i2cc_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic restartDiv;
    logic sdaLow;
    logic sdaRel;
    logic sclLow;
    logic sclRel;
  } lineCmd_t;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ST_RELSDA,
    SEQ_ST_RELSCL,
    SEQ_ST_SDALOW,
    SEQ_SP_SDALOW,
    SEQ_SP_RELSCL
  } seqState_t;

endpackage

// File: rtl/i2cc_datapath.sv
`timescale 1ns/1ps
module i2cc_datapath
  import i2cc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncMode,
  input  logic [3:0] clkSel,
  input  logic       sdaIn,
  input  logic       sclIn,
  input  lineCmd_t   cmd,
  output logic       halfTick,
  output logic       sdaOe,
  output logic       sclOe,
  output logic       busBusy
);

  localparam int LAST = SYNC_STAGES - 1;

  // half-period lookup: base table of halves, doubled for the upper codes
  function automatic logic [CNT_W-1:0] halfOf(input logic [3:0] code);
    logic [CNT_W-1:0] base;
    case (code[2:0])
      3'd0:    base = CNT_W'(14);
      3'd1:    base = CNT_W'(20);
      3'd2:    base = CNT_W'(24);
      3'd3:    base = CNT_W'(32);
      3'd4:    base = CNT_W'(40);
      3'd5:    base = CNT_W'(50);
      3'd6:    base = CNT_W'(56);
      default: base = CNT_W'(64);
    endcase
    return code[3] ? (base << 1) : base;
  endfunction

  // pad synchronizers
  logic [LAST:0] sdaSh, sclSh;
  logic          sdaPrev, sclPrev;
  logic          sdaS, sclS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaSh   <= '1;
      sclSh   <= '1;
      sdaPrev <= 1'b1;
      sclPrev <= 1'b1;
    end else begin
      sdaSh   <= {sdaSh[LAST-1:0], sdaIn};
      sclSh   <= {sclSh[LAST-1:0], sclIn};
      sdaPrev <= sdaS;
      sclPrev <= sclS;
    end
  end

  assign sdaS = sdaSh[LAST];
  assign sclS = sclSh[LAST];

  logic sclHigh, startSeen, stopSeen;
  assign sclHigh   = sclS & sclPrev;
  assign startSeen = sclHigh & sdaPrev & ~sdaS;
  assign stopSeen  = sclHigh & ~sdaPrev & sdaS;

  // occupancy flag
  always_ff @(posedge clk) begin
    if (!rstN || syncMode) busBusy <= 1'b0;
    else if (startSeen)    busBusy <= 1'b1;
    else if (stopSeen)     busBusy <= 1'b0;
  end

  // half-period counter
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (cmd.restartDiv) cnt <= halfOf(clkSel) - CNT_W'(1);
    else if (cnt != '0)      cnt <= cnt - CNT_W'(1);
  end
  assign halfTick = (cnt == '0);

  // line drivers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaOe <= 1'b0;
      sclOe <= 1'b0;
    end else begin
      if (cmd.sdaLow)      sdaOe <= 1'b1;
      else if (cmd.sdaRel) sdaOe <= 1'b0;
      if (cmd.sclLow)      sclOe <= 1'b1;
      else if (cmd.sclRel) sclOe <= 1'b0;
    end
  end

endmodule

// File: rtl/i2cc_control.sv
`timescale 1ns/1ps
module i2cc_control
  import i2cc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     syncMode,
  input  logic     wrStb,
  input  logic     wrBusy,
  input  logic     wrQual,
  input  logic     halfTick,
  output lineCmd_t cmd,
  output logic     seqActive
);

  seqState_t state, stateNext;
  logic      req;

  assign req = wrStb & ~wrQual & ~syncMode;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    unique case (state)
      SEQ_IDLE: if (req) begin
        cmd.restartDiv = 1'b1;
        if (wrBusy) begin
          stateNext  = SEQ_ST_RELSDA;
          cmd.sdaRel = 1'b1;
        end else begin
          stateNext  = SEQ_SP_SDALOW;
          cmd.sdaLow = 1'b1;
        end
      end
      SEQ_ST_RELSDA: if (halfTick) begin
        stateNext      = SEQ_ST_RELSCL;
        cmd.sclRel     = 1'b1;
        cmd.restartDiv = 1'b1;
      end
      SEQ_ST_RELSCL: if (halfTick) begin
        stateNext      = SEQ_ST_SDALOW;
        cmd.sdaLow     = 1'b1;
        cmd.restartDiv = 1'b1;
      end
      SEQ_ST_SDALOW: if (halfTick) begin
        stateNext  = SEQ_IDLE;
        cmd.sclLow = 1'b1;
      end
      SEQ_SP_SDALOW: if (halfTick) begin
        stateNext      = SEQ_SP_RELSCL;
        cmd.sclRel     = 1'b1;
        cmd.restartDiv = 1'b1;
      end
      SEQ_SP_RELSCL: if (halfTick) begin
        stateNext  = SEQ_IDLE;
        cmd.sdaRel = 1'b1;
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  assign seqActive = (state != SEQ_IDLE);

endmodule

// File: rtl/i2c_cond_master.sv
`timescale 1ns/1ps
module i2c_cond_master
  import i2cc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncMode,
  input  logic [3:0] clkSel,
  input  logic       wrStb,
  input  logic       wrBusy,
  input  logic       wrQual,
  input  logic       sdaIn,
  input  logic       sclIn,
  output logic       sdaOe,
  output logic       sclOe,
  output logic       busBusy
);

  lineCmd_t cmd;
  logic     halfTick;
  logic     seqActive;

  i2cc_control u_ctrl (
    .clk(clk), .rstN(rstN), .syncMode(syncMode),
    .wrStb(wrStb), .wrBusy(wrBusy), .wrQual(wrQual),
    .halfTick(halfTick), .cmd(cmd), .seqActive(seqActive)
  );

  i2cc_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .clkSel(clkSel),
    .sdaIn(sdaIn), .sclIn(sclIn), .cmd(cmd), .halfTick(halfTick),
    .sdaOe(sdaOe), .sclOe(sclOe), .busBusy(busBusy)
  );

endmodule

// File: rtl/i2cc_checker.sv
`timescale 1ns/1ps
module i2cc_checker (
  input logic clk,
  input logic rstN,
  input logic syncMode,
  input logic wrStb,
  input logic wrQual,
  input logic sdaOe,
  input logic sclOe,
  input logic busBusy,
  input logic seqActive
);

  AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!sdaOe && !sclOe && !busBusy)); // R8

  AST_SCL_AFTER_SDA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> (sdaOe && $past(sdaOe))); // R3

  AST_SDA_AFTER_SCL: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaOe) && !seqActive) |-> (!sclOe && $past(!sclOe))); // R4

  AST_QUAL_NOOP: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && wrQual && !seqActive) |=> ($stable(sdaOe) && $stable(sclOe))); // R5

  AST_SYNC_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    syncMode |=> !busBusy); // R6

  AST_SYNC_NO_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (syncMode && !seqActive) |=> !seqActive); // R6

endmodule

bind i2c_cond_master i2cc_checker u_chk (
  .clk(clk), .rstN(rstN), .syncMode(syncMode), .wrStb(wrStb),
  .wrQual(wrQual), .sdaOe(sdaOe), .sclOe(sclOe), .busBusy(busBusy),
  .seqActive(seqActive)
);

// File: tb/tb_i2c_cond_master.sv
`timescale 1ns/1ps
module tb_i2c_cond_master;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncMode = 1'b0;
  logic [3:0] clkSel = 4'd0;
  logic       wrStb = 1'b0, wrBusy = 1'b0, wrQual = 1'b0;
  logic       extSda = 1'b0, extScl = 1'b0;
  logic       sdaOe, sclOe, busBusy;
  logic       sdaBus, sclBus;

  assign sdaBus = ~(sdaOe | extSda);
  assign sclBus = ~(sclOe | extScl);

  always #10 clk = ~clk;

  i2c_cond_master dut (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .clkSel(clkSel),
    .wrStb(wrStb), .wrBusy(wrBusy), .wrQual(wrQual),
    .sdaIn(sdaBus), .sclIn(sclBus),
    .sdaOe(sdaOe), .sclOe(sclOe), .busBusy(busBusy)
  );

  int checks = 0;
  int fails  = 0;

  // scoreboard queues: kind 0 = START, 1 = STOP
  int    expKind[$];
  int    expGap[$];
  string expTag[$];

  function automatic int halfOf(input logic [3:0] code);
    int base;
    case (code[2:0])
      3'd0: base = 28;  3'd1: base = 40;  3'd2: base = 48;  3'd3: base = 64;
      3'd4: base = 80;  3'd5: base = 100; 3'd6: base = 112; default: base = 128;
    endcase
    if (code[3]) base = base * 2;
    return base / 2;
  endfunction

  task automatic pushExp(input int kind, input int gap, input string tag);
    expKind.push_back(kind);
    expGap.push_back(gap);
    expTag.push_back(tag);
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic writeReg(input logic b, input logic q);
    @(posedge clk); #2;
    wrStb = 1'b1; wrBusy = b; wrQual = q;
    @(posedge clk); #2;
    wrStb = 1'b0;
  endtask

  // monitor: condition events on the wired bus
  int cyc = 0, t0 = 0, tR = 0;
  bit pSda = 1'b1, pScl = 1'b1, pend = 1'b0;

  task automatic gotEvent(input int kind, input int gap);
    checks++;
    if (expKind.size() == 0) begin
      fails++;
      $display("FAIL R9: unexpected event kind %0d gap %0d, expected none", kind, gap);
    end else begin
      int    k = expKind.pop_front();
      int    g = expGap.pop_front();
      string t = expTag.pop_front();
      if (k != kind || g != gap) begin
        fails++;
        $display("FAIL %s: actual kind %0d gap %0d expected kind %0d gap %0d",
                 t, kind, gap, k, g);
      end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      pend = 1'b0;
    end else begin
      if (pSda && !sdaBus && pScl && sclBus) begin pend = 1'b1; t0 = cyc; end
      if (pScl && !sclBus && pend) begin pend = 1'b0; gotEvent(0, cyc - t0); end
      if (!pScl && sclBus) tR = cyc;
      if (!pSda && sdaBus && pScl && sclBus) gotEvent(1, cyc - tR);
    end
    pSda = sdaBus;
    pScl = sclBus;
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic startStop(input logic [3:0] code, input string tag);
    int h = halfOf(code);
    clkSel = code;
    pushExp(0, h, {tag, " R3 R7 start"});
    writeReg(1'b1, 1'b0);
    cycles(4 * h + 10);
    checkEq("R1 flag after start", busBusy, 1);
    pushExp(1, h, {tag, " R4 R7 stop"});
    writeReg(1'b0, 1'b0);
    cycles(4 * h + 10);
    checkEq("R2 flag after stop", busBusy, 0);
  endtask

  initial begin
    cycles(4);
    checkEq("R8 reset sdaOe", sdaOe, 0);
    checkEq("R8 reset sclOe", sclOe, 0);
    checkEq("R8 reset busBusy", busBusy, 0);
    rstN = 1'b1;
    cycles(3);
    checkEq("R8 after reset busBusy", busBusy, 0);

    // divider table across codes
    startStop(4'd0,  "code0");
    startStop(4'd9,  "code9");
    startStop(4'd15, "code15");
    startStop(4'd3,  "code3");
    startStop(4'd14, "code14");

    // repeated START at code 5
    begin
      int h = halfOf(4'd5);
      clkSel = 4'd5;
      pushExp(0, h, "R3 first start");
      writeReg(1'b1, 1'b0);
      cycles(4 * h + 10);
      // qualifier write while held
      writeReg(1'b0, 1'b1);
      cycles(40);
      checkEq("R5 sdaOe held", sdaOe, 1);
      checkEq("R5 sclOe held", sclOe, 1);
      checkEq("R5 flag held", busBusy, 1);
      pushExp(0, h, "R3 repeated start");
      writeReg(1'b1, 1'b0);
      cycles(4 * h + 10);
      checkEq("R3 flag after repeated start", busBusy, 1);
      // R9: STOP write during running sequence is ignored
      pushExp(0, h, "R9 start before ignored write");
      writeReg(1'b1, 1'b0);
      cycles(5);
      writeReg(1'b0, 1'b0);
      cycles(4 * h + 10);
      checkEq("R9 flag still set", busBusy, 1);
      checkEq("R9 sdaOe still low", sdaOe, 1);
      pushExp(1, h, "R4 stop code5");
      writeReg(1'b0, 1'b0);
      cycles(4 * h + 10);
      checkEq("R2 flag after stop code5", busBusy, 0);
    end

    // qualifier write while idle
    writeReg(1'b1, 1'b1);
    cycles(60);
    checkEq("R5 idle sdaOe", sdaOe, 0);
    checkEq("R5 idle sclOe", sclOe, 0);
    checkEq("R5 idle flag", busBusy, 0);

    // synchronous mode: no conditions, flag held 0
    syncMode = 1'b1;
    clkSel = 4'd0;
    writeReg(1'b1, 1'b0);
    cycles(80);
    checkEq("R6 no sda drive", sdaOe, 0);
    pushExp(0, 5, "R6 external start");
    extSda = 1'b1;
    cycles(5);
    extScl = 1'b1;
    cycles(10);
    checkEq("R6 flag stays clear", busBusy, 0);
    pushExp(1, 7, "R6 external stop");
    extScl = 1'b0;
    cycles(7);
    extSda = 1'b0;
    cycles(10);
    syncMode = 1'b0;
    cycles(5);

    // external START in I2C mode, latency check
    pushExp(0, 6, "R1 external start");
    extSda = 1'b1;
    cycles(3);
    checkEq("R1 flag within 3 cycles", busBusy, 1);
    cycles(3);
    extScl = 1'b1;
    cycles(10);

    // concurrent: STOP detection and START request in the same edge
    begin
      int h = halfOf(4'd0);
      pushExp(1, 7, "R2 external stop");
      extScl = 1'b0;
      cycles(7);
      extSda = 1'b0;              // after edge P0
      @(posedge clk); @(posedge clk); #2;   // P1, P2
      wrStb = 1'b1; wrBusy = 1'b1; wrQual = 1'b0;
      pushExp(0, h, "R3 start alongside stop detect");
      @(posedge clk); #2;         // P3: flag clears, request taken
      wrStb = 1'b0;
      checkEq("R2 flag cleared at P0+3", busBusy, 0);
      cycles(4 * h + 10);
      checkEq("R1 flag set by own start", busBusy, 1);
      pushExp(1, h, "R4 final stop");
      writeReg(1'b0, 1'b0);
      cycles(4 * h + 10);
      checkEq("R2 final flag", busBusy, 0);
    end

    cycles(20);
    checkEq("R3 R4 expected events left", expKind.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule